// File: doc/BRIEF.md
# Elastic Store with Realign Command

This block is a dual-clock elastic buffer for one direction of an E1 byte stream. Channel bytes enter on the line clock (`wclk`) and leave on the system clock (`rclk`). The storage holds two 32-byte frames. The write pointer crosses into the read domain as Gray code through a two-flop synchronizer. All pointer management takes place in the read domain: the separation check, slips and realignment.

A software align bit (`align_req`) is synchronized into the read domain and edge-detected there. A rising edge forces the read pointer to sit half a frame (16 bytes) behind the synchronized write pointer. This happens only when the pointers have drifted closer than that, and only after `clk_stable` reports that the system clock is usable. When the pointers would otherwise collide, the read pointer jumps by one full frame and `slip` pulses for one cycle. The bytes in flight at that moment are lost or repeated, which is the accepted cost of a slip.

Top module: `elastic_store`

## Requirements
- R1: While `rrst_n` is low, `rd_data` is 0, `slip` is 0, `align_ack` is 0 and `rd_fill` is 0.
- R2: Bytes leave in the order they were written. A read strobe of one `rclk` cycle presents the next byte on `rd_data` after the following rising `rclk` edge. Within 8 `rclk` cycles of the last write, `rd_fill` equals bytes written minus bytes read, modulo 64.
- R3: An align is executed when three conditions hold: a 0-to-1 transition of `align_req` is seen in the read domain, `clk_stable` is 1, and `rd_fill` is below 16. The read pointer is then set 16 places behind the synchronized write pointer. With writes stopped, `rd_fill` reads 16 and the next byte read is the one written 16 bytes before the last write. `align_ack` pulses for one cycle.
- R4: Holding `align_req` high causes no further align. A new align requires the bit to go to 0 and then back to 1.
- R5: A rising edge of `align_req` while `rd_fill` is 16 or more is ignored. The read pointer is left unchanged, so the next byte read continues the sequence, and `align_ack` does not pulse.
- R6: While `clk_stable` is 0, edges of `align_req` are ignored. If the bit rose while the clock was not stable and stays high, no align happens when `clk_stable` later goes to 1.
- R7: A read strobe when `rd_fill` is 0 reads no byte. Instead it raises `slip` for exactly one cycle and advances the read pointer by 32, so `rd_fill` becomes 32.
- R8: When `rd_fill` reaches 60 or more, `slip` pulses for one cycle and the read pointer advances by 32, so `rd_fill` drops by 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Line-side write clock |
| wrst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Write strobe, one byte per asserted cycle |
| wr_data | input | 8 | Byte to store |
| rclk | input | 1 | System-side read clock |
| rrst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_en | input | 1 | Read strobe, one byte per asserted cycle |
| rd_data | output | 8 | Last byte read |
| clk_stable | input | 1 | Read clock is running and stable; gates aligns |
| align_req | input | 1 | Software align bit, acted on at its rising edge |
| align_ack | output | 1 | One-cycle pulse when an align was executed |
| slip | output | 1 | One-cycle pulse when the read pointer jumped a frame |
| rd_fill | output | 6 | Pointer separation seen in the read domain |

## Verification
A wrong read pointer shows at once as a wrong `rd_fill` value. It also shows on the next read as a byte out of sequence on `rd_data`, one `rclk` cycle after the strobe. A fault in the write pointer or its crossing appears as a `rd_fill` that fails to settle to the written count within a few read cycles. A faulty edge detector or stability gate shows as an `align_ack` pulse that is missing or extra, together with a 16-byte gap that appears or fails to appear in `rd_fill`. Faulty slip logic shows as `rd_fill` failing to move by 32 in the cycle after an underrun or overrun.

// File: rtl/es_pkg.sv
// Shared types for the elastic store.
// Assumes: all users are in the read clock domain.
package es_pkg;
    // Action the read controller takes in a given rclk cycle.
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_POP   = 2'd1,
        RD_SLIP  = 2'd2,
        RD_ALIGN = 2'd3
    } rd_action_t;
endpackage

// File: rtl/es_wr_side.sv
// Write side of the elastic store: the byte storage, the binary write pointer
// and its registered Gray copy for the clock crossing. The storage is read
// asynchronously by the read domain through rd_addr.
// Assumes: the write pointer only ever advances by one, so its Gray copy
// changes one bit per update.
module es_wr_side #(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word,
    output logic [AW-1:0] wgray
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] wptr_nx;

    assign wptr_nx = wptr + AW'(1);

    // Store the incoming byte at the current write position.
    always_ff @(posedge wclk) begin
        if (wr_en) begin
            mem[wptr] <= wr_data;
        end
    end

    // Advance the write pointer and its Gray image together.
    always_ff @(posedge wclk) begin
        if (!wrst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (wr_en) begin
            wptr  <= wptr_nx;
            wgray <= wptr_nx ^ (wptr_nx >> 1);
        end
    end

    // Asynchronous read port used by the read domain.
    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/es_ptr_sync.sv
// Brings a Gray-coded pointer into the read clock domain through two flops
// and converts it back to binary.
// Assumes: the source changes at most one bit between samples.
module es_ptr_sync #(
    parameter int AW = 6
) (
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic [AW-1:0] gray_in,
    output logic [AW-1:0] bin_out
);
    logic [AW-1:0] meta;
    logic [AW-1:0] gray_s;

    // Two-stage synchronizer for the Gray pointer.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            meta   <= '0;
            gray_s <= '0;
        end else begin
            meta   <= gray_in;
            gray_s <= meta;
        end
    end

    // Gray to binary: each bit is the parity of all higher Gray bits.
    for (genvar i = 0; i < AW; i++) begin : g_g2b
        assign bin_out[i] = ^gray_s[AW-1:i];
    end
endmodule

// File: rtl/es_align_edge.sv
// Synchronizes the software align bit into the read domain and produces a
// one-cycle pulse on its rising edge, gated by the clock-stable input.
// Assumes: clk_stable is already synchronous to rclk. An edge that occurs
// while clk_stable is low is consumed and not replayed later.
module es_align_edge (
    input  logic rclk,
    input  logic rrst_n,
    input  logic align_req,
    input  logic clk_stable,
    output logic align_pulse
);
    logic s1, s2, s3;

    // Synchronizer chain plus one delay stage for edge detection.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= align_req;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Rising edge of the synchronized bit, accepted only on a stable clock.
    assign align_pulse = s2 & ~s3 & clk_stable;
endmodule

// File: rtl/es_rd_ctrl.sv
// Read-domain controller. Computes the pointer separation against the
// synchronized write pointer and picks one action per cycle. An align
// (only when the gap is under half a frame) ranks above a slip (underrun on
// a read strobe, or gap at the overrun limit), which ranks above a normal
// read. A slip moves the read pointer by one frame.
// Assumes: wptr_s is the synchronized binary write pointer.
module es_rd_ctrl
    import es_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 64,
    parameter int FRAME = 32,
    parameter int GUARD = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int HALF = FRAME / 2
) (
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_en,
    input  logic          align_pulse,
    input  logic [AW-1:0] wptr_s,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] fill,
    output logic          slip,
    output logic          align_ack
);
    localparam logic [AW-1:0] HALF_L  = AW'(HALF);
    localparam logic [AW-1:0] FRAME_L = AW'(FRAME);
    localparam logic [AW-1:0] OVR_L   = AW'(DEPTH - GUARD);

    logic [AW-1:0] rptr;
    logic [AW-1:0] gap;
    rd_action_t    act;

    assign gap = wptr_s - rptr;

    // Choose this cycle's action by priority.
    always_comb begin
        if (align_pulse && (gap < HALF_L)) begin
            act = RD_ALIGN;
        end else if ((rd_en && (gap == '0)) || (gap >= OVR_L)) begin
            act = RD_SLIP;
        end else if (rd_en) begin
            act = RD_POP;
        end else begin
            act = RD_IDLE;
        end
    end

    // Update the read pointer, output byte and status pulses.
    always_ff @(posedge rclk) begin
        if (!rrst_n) begin
            rptr      <= '0;
            rd_data   <= '0;
            slip      <= 1'b0;
            align_ack <= 1'b0;
        end else begin
            slip      <= (act == RD_SLIP);
            align_ack <= (act == RD_ALIGN);
            case (act)
                RD_ALIGN: rptr <= wptr_s - HALF_L;
                RD_SLIP:  rptr <= rptr + FRAME_L;
                RD_POP: begin
                    rd_data <= rd_word;
                    rptr    <= rptr + AW'(1);
                end
                default: rptr <= rptr;
            endcase
        end
    end

    assign rd_addr = rptr;
    assign fill    = gap;
endmodule

// File: rtl/elastic_store.sv
// Top of the elastic store: write side in the wclk domain, pointer crossing,
// align edge detection and read control in the rclk domain.
// Assumes: the two resets are each synchronous to their own clock.
module elastic_store #(
    parameter int DW     = 8,
    parameter int FRAME  = 32,
    parameter int FRAMES = 2,
    parameter int GUARD  = 4,
    localparam int DEPTH = FRAME * FRAMES,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          clk_stable,
    input  logic          align_req,
    output logic          align_ack,
    output logic          slip,
    output logic [AW-1:0] rd_fill
);
    logic [AW-1:0] wgray;
    logic [AW-1:0] wptr_s;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_word;
    logic          align_pulse;

    es_wr_side #(.DW(DW), .DEPTH(DEPTH)) u_wr (
        .wclk    (wclk),
        .wrst_n  (wrst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word),
        .wgray   (wgray)
    );

    es_ptr_sync #(.AW(AW)) u_sync (
        .rclk    (rclk),
        .rrst_n  (rrst_n),
        .gray_in (wgray),
        .bin_out (wptr_s)
    );

    es_align_edge u_edge (
        .rclk        (rclk),
        .rrst_n      (rrst_n),
        .align_req   (align_req),
        .clk_stable  (clk_stable),
        .align_pulse (align_pulse)
    );

    es_rd_ctrl #(.DW(DW), .DEPTH(DEPTH), .FRAME(FRAME), .GUARD(GUARD)) u_rd (
        .rclk        (rclk),
        .rrst_n      (rrst_n),
        .rd_en       (rd_en),
        .align_pulse (align_pulse),
        .wptr_s      (wptr_s),
        .rd_word     (rd_word),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .fill        (rd_fill),
        .slip        (slip),
        .align_ack   (align_ack)
    );
endmodule

// File: rtl/es_checker.sv
// Assertion checker for the elastic store, bound to the top module.
// Assumes: it observes only top-level ports in the read domain.
module es_checker #(
    parameter int AW    = 6,
    parameter int FRAME = 32,
    parameter int GUARD = 4,
    localparam int HALF = FRAME / 2,
    localparam int DEPTH = 1 << AW
) (
    input logic          rclk,
    input logic          rrst_n,
    input logic          rd_en,
    input logic          clk_stable,
    input logic          align_ack,
    input logic          slip,
    input logic [AW-1:0] rd_fill
);
    // R3: after an align the gap is half a frame (plus at most one new write).
    a_r3_half_gap: assert property (@(posedge rclk) disable iff (!rrst_n)
        align_ack |-> (int'(rd_fill) >= HALF && int'(rd_fill) <= HALF + 1));

    // R4: an align is a single-cycle event.
    a_r4_single_ack: assert property (@(posedge rclk) disable iff (!rrst_n)
        align_ack |=> !align_ack);

    // R5: an align only follows a gap below half a frame.
    a_r5_small_gap_only: assert property (@(posedge rclk) disable iff (!rrst_n)
        align_ack |-> (int'($past(rd_fill)) < HALF));

    // R6: an align only happens with the clock reported stable.
    a_r6_stable_only: assert property (@(posedge rclk) disable iff (!rrst_n)
        align_ack |-> $past(clk_stable));

    // R7 and R8: a slip has a cause, underrun on a read or gap at the limit.
    a_r7_slip_cause: assert property (@(posedge rclk) disable iff (!rrst_n)
        slip |-> ($past(rd_en && rd_fill == '0) || int'($past(rd_fill)) >= DEPTH - GUARD));

    // R7: the slip pulse lasts one cycle.
    a_r7_slip_pulse: assert property (@(posedge rclk) disable iff (!rrst_n)
        slip |=> !slip);

    // R8: slip and align never coincide.
    a_r8_exclusive: assert property (@(posedge rclk) disable iff (!rrst_n)
        !(slip && align_ack));
endmodule

bind elastic_store es_checker #(.AW(AW), .FRAME(FRAME), .GUARD(GUARD)) u_chk (
    .rclk       (rclk),
    .rrst_n     (rrst_n),
    .rd_en      (rd_en),
    .clk_stable (clk_stable),
    .align_ack  (align_ack),
    .slip       (slip),
    .rd_fill    (rd_fill)
);

// File: tb/elastic_store_test.sv
// Self-checking bench for the elastic store with unequal clocks.
module elastic_store_test;
    localparam int CLK_PERIOD  = 10;
    localparam int WCLK_PERIOD = 13;

    logic       wclk = 1'b0, rclk = 1'b0;
    logic       wrst_n = 1'b0, rrst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       clk_stable = 1'b0, align_req = 1'b0;
    logic       align_ack, slip;
    logic [5:0] rd_fill;

    int checks = 0, fails = 0;
    int wcount = 0, rcount = 0;
    int ack_cnt = 0, slip_cnt = 0;

    // Table: writes[23:16], reads[15:8], expected fill[7:0].
    localparam logic [23:0] VEC [6] = '{
        24'h06_00_06, 24'h00_04_02, 24'h0A_03_09,
        24'h02_00_0B, 24'h00_05_06, 24'h04_04_06
    };

    elastic_store uut (
        .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data),
        .clk_stable(clk_stable), .align_req(align_req),
        .align_ack(align_ack), .slip(slip), .rd_fill(rd_fill)
    );

    always #(CLK_PERIOD / 2) rclk = ~rclk;
    always #(WCLK_PERIOD / 2.0) wclk = ~wclk;

    always @(negedge rclk) begin
        if (align_ack) ack_cnt++;
        if (slip) slip_cnt++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_write(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wr_en = 1'b1;
            wr_data = 8'(wcount + 1);
            @(negedge wclk);
            wr_en = 1'b0;
            wcount++;
        end
    endtask

    task automatic do_read(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge rclk);
            rd_en = 1'b1;
            @(negedge rclk);
            rd_en = 1'b0;
            check(rd_data == 8'(rcount + 1), req, int'(rd_data), (rcount + 1) % 256);
            rcount++;
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge rclk);
        // R1: reset state
        check(rd_data == 0, "R1", int'(rd_data), 0);
        check(slip == 0, "R1", int'(slip), 0);
        check(align_ack == 0, "R1", int'(align_ack), 0);
        check(rd_fill == 0, "R1", int'(rd_fill), 0);
        wrst_n = 1'b1;
        rrst_n = 1'b1;
        settle();

        // R2: table of write/read bursts with fill and order checks
        for (int v = 0; v < 6; v++) begin
            do_write(int'(VEC[v][23:16]));
            settle();
            do_read(int'(VEC[v][15:8]), "R2");
            settle();
            check(rd_fill == VEC[v][5:0], "R2", int'(rd_fill), int'(VEC[v][7:0]));
        end

        // R6: edges ignored while the clock is not stable
        align_req = 1'b1;
        settle();
        check(ack_cnt == 0, "R6", ack_cnt, 0);
        check(rd_fill == 6, "R6", int'(rd_fill), 6);
        clk_stable = 1'b1;
        settle();
        check(ack_cnt == 0, "R6", ack_cnt, 0);
        check(rd_fill == 6, "R6", int'(rd_fill), 6);

        // R3: clear then set at small gap executes the align
        align_req = 1'b0;
        settle();
        align_req = 1'b1;
        settle();
        check(ack_cnt == 1, "R3", ack_cnt, 1);
        check(rd_fill == 16, "R3", int'(rd_fill), 16);
        rcount = wcount - 16;
        // R4: holding the bit high does nothing more
        settle();
        check(ack_cnt == 1, "R4", ack_cnt, 1);
        do_read(1, "R3");

        // R5: align at a gap of 16 or more is ignored
        do_write(20);
        settle();
        check(rd_fill == 35, "R5", int'(rd_fill), 35);
        align_req = 1'b0;
        settle();
        align_req = 1'b1;
        settle();
        check(ack_cnt == 1, "R5", ack_cnt, 1);
        check(rd_fill == 35, "R5", int'(rd_fill), 35);
        do_read(1, "R5");

        // R2: drain to empty, order preserved
        do_read(34, "R2");
        check(rd_fill == 0, "R2", int'(rd_fill), 0);

        // R7: read at empty slips one frame
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
        check(slip == 1, "R7", int'(slip), 1);
        @(negedge rclk);
        check(slip == 0, "R7", int'(slip), 0);
        check(rd_fill == 32, "R7", int'(rd_fill), 32);
        check(slip_cnt == 1, "R7", slip_cnt, 1);

        // R8: filling to the limit slips one frame
        do_write(28);
        settle();
        check(slip_cnt == 2, "R8", slip_cnt, 2);
        check(rd_fill == 28, "R8", int'(rd_fill), 28);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule